// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

This block supervises software through two countdown phases that run one after the other. A rising enable loads the first phase from its own 20-bit preload and starts it. If software fails to kick the timer before that phase runs out, the block sends a one-cycle interrupt on the selected channel and loads the second phase from a second preload. If the second phase also runs out, the block asks for a system reset and records that the watchdog caused it, in a flag that stays set until software clears it.

Both phases count in steps of a prescaler driven by a reference tick. The tick is nominally 33 MHz. One step is either 2^15 ticks (slow scale, about 1 kHz) or 2^5 ticks (fast scale, about 1 MHz). A timeout therefore lasts the preload times the step length. A free-run option starts the first phase again after every final expiry.

A write-once lock freezes the enable, free-run and lock controls until reset. The configuration word and the preloads stay writable. The host bus decode, the unlock protection, the reset action and the interrupt controller all sit outside this block.

Top module: `wdog2_top`

## Requirements
- R1: After reset the outputs are low, `stage_num` is 0 (idle) and `prev_reboot` is 0. The control defaults are: reboot enabled, slow scale, interrupt type 0, free-run off, unlocked, disabled. Both preloads reset to 0xFFFFF.
- R2: A control write that turns enable from 0 to 1 loads phase 1 from preload 1, and `stage_num` reads 1 after that clock edge. `stage_num` uses 0 for idle, 1 for phase 1 and 2 for phase 2.
- R3: With `ref_tick` held high, a phase loaded with value P at clock edge E expires at edge E + P·2^5 when `cfg_fast` is 1, and at edge E + P·2^15 when it is 0.
- R4: When phase 1 expires, the block pulses one output for one cycle, chosen by the 2-bit type: 0 pulses `irq_pulse`, 2 pulses `smi_pulse`, and 1 or 3 pulses neither. It then loads phase 2 from preload 2.
- R5: When phase 2 expires with reboot enabled (`cfg_reboot_n` = 0), `rst_req` pulses for one cycle and `prev_reboot` is set. With `cfg_reboot_n` = 1, neither happens. Without free-run the stage then goes idle.
- R6: With free-run set, phase 1 restarts from preload 1 when phase 2 expires, whether or not a reset was requested.
- R7: An accepted control write with enable 0 stops the count at once and leaves the block idle with no further pulses. A kick while disabled is ignored.
- R8: A kick while enabled restarts phase 1 from preload 1, from phase 1, phase 2 or idle.
- R9: Once a control write with the lock bit set is accepted, every later control write is ignored until reset.
- R10: `flag_clr` clears `prev_reboot`. If a phase-2 expiry sets the flag in the same cycle, the flag stays set.
- R11: A kick in the same cycle as an expiry wins: phase 1 restarts and the expiry's pulse is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable (33 MHz rate) |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_reboot_n | input | 1 | 0 = reset request on final expiry enabled |
| cfg_fast | input | 1 | 1 = 2^5-tick step, 0 = 2^15-tick step |
| cfg_itype | input | 2 | Phase-1 interrupt type: 0 IRQ, 2 SMI, 1/3 none |
| lock_wr | input | 1 | Write strobe for the lockable controls |
| lock_set | input | 1 | Lock bit written with `lock_wr` |
| lock_en | input | 1 | Enable bit written with `lock_wr` |
| lock_free | input | 1 | Free-run bit written with `lock_wr` |
| pre1_wr | input | 1 | Write `pre_data` into preload 1 |
| pre2_wr | input | 1 | Write `pre_data` into preload 2 |
| pre_data | input | 20 | Preload value |
| kick | input | 1 | Reload pulse that restarts phase 1 |
| flag_clr | input | 1 | Clears the previous-reboot flag |
| irq_pulse | output | 1 | One-cycle IRQ-channel interrupt |
| smi_pulse | output | 1 | One-cycle SMI-channel interrupt |
| rst_req | output | 1 | One-cycle reset request |
| prev_reboot | output | 1 | Sticky: watchdog requested the last reset |
| stage_num | output | 2 | 0 idle, 1 phase 1, 2 phase 2 |

## Verification
The two collisions that matter are a kick landing on the very clock edge where a phase runs out, and a flag clear arriving on the edge where a phase-2 expiry sets the flag. The bench counts edges from each restart and drives `kick` so that the design samples it exactly on the computed expiry edge of phase 1, and then of phase 2. The queued expected pulses then move to the new restart time, and the monitor reports any pulse that appears at the suppressed time. For the flag, `flag_clr` is driven for the single edge of a phase-2 expiry, and `prev_reboot` must read 1 on the following sample.

// File: rtl/wdog2_pkg.sv
// Package: shared encodings for the two-stage watchdog.
// Assumes: stage code values are visible at the top as a 2-bit number.
package wdog2_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2
    } stage_e;

    localparam logic [1:0] ITYPE_IRQ = 2'd0;
    localparam logic [1:0] ITYPE_SMI = 2'd2;
endpackage

// File: rtl/wdog2_regs.sv
// Module: control and preload storage for the watchdog.
// Holds the configuration fields, the lockable controls and both preloads.
// Produces one-cycle start/stop requests when an accepted control write
// changes the enable. Assumes write strobes are single-cycle.
module wdog2_regs #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_reboot_n,
    input  logic             cfg_fast,
    input  logic [1:0]       cfg_itype,
    input  logic             lock_wr,
    input  logic             lock_set,
    input  logic             lock_en,
    input  logic             lock_free,
    input  logic             pre1_wr,
    input  logic             pre2_wr,
    input  logic [CNT_W-1:0] pre_data,
    output logic             reboot_en,
    output logic             fast,
    output logic [1:0]       itype,
    output logic             free_run,
    output logic             enabled,
    output logic             locked,
    output logic             en_start,
    output logic             en_stop,
    output logic [CNT_W-1:0] pre1,
    output logic [CNT_W-1:0] pre2
);
    localparam logic [CNT_W-1:0] PRE_RST = '1;

    logic reboot_n_q;
    logic lock_ok;

    // A control write takes effect only while the lock is open.
    assign lock_ok   = lock_wr & ~locked;
    assign en_start  = lock_ok & lock_en & ~enabled;
    assign en_stop   = lock_ok & ~lock_en;
    assign reboot_en = ~reboot_n_q;

    // Configuration fields; never locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reboot_n_q <= 1'b0;
            fast       <= 1'b0;
            itype      <= 2'd0;
        end else if (cfg_wr) begin
            reboot_n_q <= cfg_reboot_n;
            fast       <= cfg_fast;
            itype      <= cfg_itype;
        end
    end

    // Lockable controls; frozen once the lock bit is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            enabled  <= 1'b0;
            free_run <= 1'b0;
        end else if (lock_ok) begin
            locked   <= lock_set;
            enabled  <= lock_en;
            free_run <= lock_free;
        end
    end

    // Preload registers for the two phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre1 <= PRE_RST;
            pre2 <= PRE_RST;
        end else begin
            if (pre1_wr) pre1 <= pre_data;
            if (pre2_wr) pre2 <= pre_data;
        end
    end
endmodule

// File: rtl/wdog2_prescale.sv
// Module: step prescaler.
// Counts reference ticks and issues one step every 2^FAST_SHIFT or
// 2^SLOW_SHIFT ticks. It is cleared whenever the phase reloads or the
// timer is idle, so every phase starts on a full step.
// Assumes FAST_SHIFT < SLOW_SHIFT.
module wdog2_prescale #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fast,
    input  logic run,
    input  logic reload,
    output logic step
);
    localparam int PRE_W = SLOW_SHIFT;
    localparam logic [PRE_W-1:0] SLOW_LAST = '1;
    localparam logic [PRE_W-1:0] FAST_LAST =
        {{(SLOW_SHIFT-FAST_SHIFT){1'b0}}, {FAST_SHIFT{1'b1}}};
    localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [PRE_W-1:0] pre_q;
    logic             hit;

    // Terminal count for the selected scale.
    assign hit  = (pre_q == (fast ? FAST_LAST : SLOW_LAST));
    assign step = run & ref_tick & hit;

    // Tick counter, wrapped at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || reload || !run) begin
            pre_q <= '0;
        end else if (ref_tick) begin
            pre_q <= hit ? '0 : pre_q + PRE_ONE;
        end
    end
endmodule

// File: rtl/wdog2_stage.sv
// Module: phase sequencer and down-counter.
// Tracks the current phase, counts steps down from the preload and
// produces the registered interrupt, reset-request and flag outputs.
// Priority per cycle: stop > restart of phase 1 > expiry > count.
module wdog2_stage
    import wdog2_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             en_start,
    input  logic             en_stop,
    input  logic             kick,
    input  logic             step,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    input  logic             reboot_en,
    input  logic             free_run,
    input  logic [1:0]       itype,
    input  logic             flag_clr,
    output stage_e           stage_q,
    output logic             run,
    output logic             reload,
    output logic             irq_pulse,
    output logic             smi_pulse,
    output logic             rst_req,
    output logic             prev_reboot
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam int               N_CHAN  = 2;
    localparam logic [2*N_CHAN-1:0] CHAN_CODES = {ITYPE_SMI, ITYPE_IRQ};

    logic [CNT_W-1:0]  cnt_q;
    logic              restart1;
    logic              expire;
    logic              exp1;
    logic              exp2;
    logic [N_CHAN-1:0] chan_q;

    // Event decode for this cycle.
    assign run      = (stage_q != ST_IDLE);
    assign restart1 = en_start | (enabled & kick & ~en_stop);
    assign expire   = run & step & (cnt_q <= CNT_ONE);
    assign exp1     = expire & ~restart1 & ~en_stop & (stage_q == ST_ONE);
    assign exp2     = expire & ~restart1 & ~en_stop & (stage_q == ST_TWO);
    assign reload   = en_stop | restart1 | expire;

    // Phase state and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (en_stop) begin
            stage_q <= ST_IDLE;
        end else if (restart1) begin
            stage_q <= ST_ONE;
            cnt_q   <= pre1;
        end else if (exp1) begin
            stage_q <= ST_TWO;
            cnt_q   <= pre2;
        end else if (exp2) begin
            if (free_run) begin
                stage_q <= ST_ONE;
                cnt_q   <= pre1;
            end else begin
                stage_q <= ST_IDLE;
            end
        end else if (run && step) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // One registered pulse per interrupt channel, chosen by type code.
    for (genvar gi = 0; gi < N_CHAN; gi++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) chan_q[gi] <= 1'b0;
            else        chan_q[gi] <= exp1 && (itype == CHAN_CODES[2*gi +: 2]);
        end
    end
    assign irq_pulse = chan_q[0];
    assign smi_pulse = chan_q[1];

    // Reset request pulse and sticky cause flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req     <= 1'b0;
            prev_reboot <= 1'b0;
        end else begin
            rst_req <= exp2 & reboot_en;
            if (exp2 && reboot_en) prev_reboot <= 1'b1;
            else if (flag_clr)     prev_reboot <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog2_top.sv
// Module: two-stage watchdog top level.
// Connects control storage, prescaler and phase sequencer.
// Assumes all strobes are synchronous to clk; ref_tick is an enable.
module wdog2_top
    import wdog2_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             cfg_wr,
    input  logic             cfg_reboot_n,
    input  logic             cfg_fast,
    input  logic [1:0]       cfg_itype,
    input  logic             lock_wr,
    input  logic             lock_set,
    input  logic             lock_en,
    input  logic             lock_free,
    input  logic             pre1_wr,
    input  logic             pre2_wr,
    input  logic [CNT_W-1:0] pre_data,
    input  logic             kick,
    input  logic             flag_clr,
    output logic             irq_pulse,
    output logic             smi_pulse,
    output logic             rst_req,
    output logic             prev_reboot,
    output logic [1:0]       stage_num
);
    logic             reboot_en_w;
    logic             fast_w;
    logic [1:0]       itype_w;
    logic             free_run_w;
    logic             enabled_w;
    logic             locked_w;
    logic             en_start_w;
    logic             en_stop_w;
    logic [CNT_W-1:0] pre1_w;
    logic [CNT_W-1:0] pre2_w;
    logic             step_w;
    logic             run_w;
    logic             reload_w;
    stage_e           stage_w;

    wdog2_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_reboot_n (cfg_reboot_n),
        .cfg_fast     (cfg_fast),
        .cfg_itype    (cfg_itype),
        .lock_wr      (lock_wr),
        .lock_set     (lock_set),
        .lock_en      (lock_en),
        .lock_free    (lock_free),
        .pre1_wr      (pre1_wr),
        .pre2_wr      (pre2_wr),
        .pre_data     (pre_data),
        .reboot_en    (reboot_en_w),
        .fast         (fast_w),
        .itype        (itype_w),
        .free_run     (free_run_w),
        .enabled      (enabled_w),
        .locked       (locked_w),
        .en_start     (en_start_w),
        .en_stop      (en_stop_w),
        .pre1         (pre1_w),
        .pre2         (pre2_w)
    );

    wdog2_prescale #(.SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .fast     (fast_w),
        .run      (run_w),
        .reload   (reload_w),
        .step     (step_w)
    );

    wdog2_stage #(.CNT_W(CNT_W)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .enabled     (enabled_w),
        .en_start    (en_start_w),
        .en_stop     (en_stop_w),
        .kick        (kick),
        .step        (step_w),
        .pre1        (pre1_w),
        .pre2        (pre2_w),
        .reboot_en   (reboot_en_w),
        .free_run    (free_run_w),
        .itype       (itype_w),
        .flag_clr    (flag_clr),
        .stage_q     (stage_w),
        .run         (run_w),
        .reload      (reload_w),
        .irq_pulse   (irq_pulse),
        .smi_pulse   (smi_pulse),
        .rst_req     (rst_req),
        .prev_reboot (prev_reboot)
    );

    // Expose the phase code.
    assign stage_num = stage_w;
endmodule

// File: rtl/wdog2_chk.sv
// Module: property checker for wdog2_top, attached by bind below.
// Observes ports plus the enable and lock state from the control storage.
module wdog2_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       kick,
    input logic       lock_wr,
    input logic       flag_clr,
    input logic       irq_pulse,
    input logic       smi_pulse,
    input logic       rst_req,
    input logic       prev_reboot,
    input logic [1:0] stage_num,
    input logic       enabled,
    input logic       locked
);
    a_r2_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
        stage_num != 2'd3);

    a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_pulse, smi_pulse, rst_req}));

    a_r4_irq_in_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse || smi_pulse) |-> stage_num == 2'd2);

    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r5_rst_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> prev_reboot);

    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> stage_num == 2'd0);

    a_r8_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && enabled && !lock_wr) |=> stage_num == 2'd1);

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_reboot && !flag_clr) |=> prev_reboot);
endmodule

bind wdog2_top wdog2_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick        (kick),
    .lock_wr     (lock_wr),
    .flag_clr    (flag_clr),
    .irq_pulse   (irq_pulse),
    .smi_pulse   (smi_pulse),
    .rst_req     (rst_req),
    .prev_reboot (prev_reboot),
    .stage_num   (stage_num),
    .enabled     (enabled_w),
    .locked      (locked_w)
);

// File: tb/sim_wdog2_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for wdog2_top. Driver tasks queue the expected pulses
// with their edge number; a negedge monitor matches every observed pulse.
module sim_wdog2_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        cfg_wr = 1'b0, cfg_reboot_n = 1'b0, cfg_fast = 1'b0;
    logic [1:0]  cfg_itype = 2'd0;
    logic        lock_wr = 1'b0, lock_set = 1'b0, lock_en = 1'b0, lock_free = 1'b0;
    logic        pre1_wr = 1'b0, pre2_wr = 1'b0;
    logic [19:0] pre_data = '0;
    logic        kick = 1'b0, flag_clr = 1'b0;
    logic        irq_pulse, smi_pulse, rst_req, prev_reboot;
    logic [1:0]  stage_num;

    typedef struct {
        int    at;
        int    kind;
        string req;
    } ev_t;

    ev_t  exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    localparam int FST = 32;

    always #2.5 clk = ~clk;

    // Edge counter: after edge k, cyc == k.
    always @(posedge clk) cyc <= cyc + 1;

    wdog2_top u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .cfg_wr(cfg_wr), .cfg_reboot_n(cfg_reboot_n), .cfg_fast(cfg_fast),
        .cfg_itype(cfg_itype), .lock_wr(lock_wr), .lock_set(lock_set),
        .lock_en(lock_en), .lock_free(lock_free), .pre1_wr(pre1_wr),
        .pre2_wr(pre2_wr), .pre_data(pre_data), .kick(kick),
        .flag_clr(flag_clr), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
        .rst_req(rst_req), .prev_reboot(prev_reboot), .stage_num(stage_num)
    );

    function automatic string kname(int k);
        return (k == 0) ? "irq" : (k == 1) ? "smi" : "rst";
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(int kind, int at, string req);
        ev_t e;
        e.at = at; e.kind = kind; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic mon_one(logic seen, int kind);
        if (seen) begin
            n_chk++;
            if (exp_q.size() > 0 && exp_q[0].at == cyc && exp_q[0].kind == kind) begin
                void'(exp_q.pop_front());
            end else begin
                n_err++;
                $display("FAIL %s unexpected %s pulse: actual cycle %0d expected cycle %0d",
                         (exp_q.size() > 0) ? exp_q[0].req : "R7", kname(kind), cyc,
                         (exp_q.size() > 0) ? exp_q[0].at : -1);
            end
        end
    endtask

    // Monitor: match pulses against the queue, report missed items.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                n_chk++;
                n_err++;
                $display("FAIL %s missing %s pulse: actual none expected cycle %0d",
                         exp_q[0].req, kname(exp_q[0].kind), exp_q[0].at);
                void'(exp_q.pop_front());
            end
            mon_one(irq_pulse, 0);
            mon_one(smi_pulse, 1);
            mon_one(rst_req, 2);
        end
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(negedge clk) begin
        if (!done && cyc >= 190000) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic rn, logic f, logic [1:0] it);
        cfg_reboot_n = rn; cfg_fast = f; cfg_itype = it; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic lock_write(logic s, logic en, logic fr, output int e0);
        lock_set = s; lock_en = en; lock_free = fr; lock_wr = 1'b1;
        e0 = cyc + 1;
        @(negedge clk);
        lock_wr = 1'b0;
    endtask

    task automatic pre_write(int sel, logic [19:0] v);
        pre_data = v;
        if (sel == 1) pre1_wr = 1'b1; else pre2_wr = 1'b1;
        @(negedge clk);
        pre1_wr = 1'b0; pre2_wr = 1'b0;
    endtask

    task automatic kick_now(output int k);
        kick = 1'b1;
        k = cyc + 1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        int e0, k1, k2, dummy;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", int'(irq_pulse | smi_pulse | rst_req), 0, "pulses in reset");
        chk("R1", int'(stage_num), 0, "stage in reset");
        chk("R1", int'(prev_reboot), 0, "flag in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", int'(stage_num), 0, "stage after reset");

        // R2 R3 R4 R5: basic run, fast scale, IRQ type, reboot enabled
        pre_write(1, 20'd3);
        pre_write(2, 20'd2);
        cfg_write(1'b0, 1'b1, 2'd0);
        lock_write(1'b0, 1'b1, 1'b0, e0);
        chk("R2", int'(stage_num), 1, "stage after enable");
        expect_ev(0, e0 + 3*FST, "R4");
        expect_ev(2, e0 + 5*FST, "R5");
        wait_until(e0 + 3*FST - 1);
        chk("R3", int'(stage_num), 1, "stage just before phase-1 expiry");
        wait_until(e0 + 3*FST);
        chk("R4", int'(stage_num), 2, "stage after phase-1 expiry");
        wait_until(e0 + 5*FST);
        chk("R5", int'(prev_reboot), 1, "flag after final expiry");
        @(negedge clk);
        chk("R5", int'(stage_num), 0, "idle after final expiry");
        drain();

        // R10: flag clear
        clr_flag();
        chk("R10", int'(prev_reboot), 0, "flag after clear");

        // R4 R5: SMI type, reboot disabled
        lock_write(1'b0, 1'b0, 1'b0, dummy);
        cfg_write(1'b1, 1'b1, 2'd2);
        lock_write(1'b0, 1'b1, 1'b0, e0);
        expect_ev(1, e0 + 3*FST, "R4");
        wait_until(e0 + 5*FST + 4);
        chk("R5", int'(prev_reboot), 0, "flag with reboot disabled");
        chk("R5", int'(stage_num), 0, "idle with reboot disabled");
        drain();

        // R6 R4: free-run, interrupt type 3 (none)
        lock_write(1'b0, 1'b0, 1'b0, dummy);
        cfg_write(1'b0, 1'b1, 2'd3);
        lock_write(1'b0, 1'b1, 1'b1, e0);
        expect_ev(2, e0 + 5*FST, "R6");
        expect_ev(2, e0 + 10*FST, "R6");
        wait_until(e0 + 5*FST + 1);
        chk("R6", int'(stage_num), 1, "phase 1 restarted by free-run");
        wait_until(e0 + 10*FST);
        lock_write(1'b0, 1'b0, 1'b0, dummy);
        chk("R7", int'(stage_num), 0, "stopped after disable");
        drain();
        clr_flag();

        // R7: disable mid-count, then kick while disabled
        cfg_write(1'b0, 1'b1, 2'd0);
        lock_write(1'b0, 1'b1, 1'b0, e0);
        repeat (40) @(negedge clk);
        lock_write(1'b0, 1'b0, 1'b0, dummy);
        chk("R7", int'(stage_num), 0, "idle after disable in phase 1");
        repeat (200) @(negedge clk);
        kick_now(dummy);
        chk("R7", int'(stage_num), 0, "kick while disabled ignored");
        repeat (200) @(negedge clk);

        // R8: kick in phase 1 and in phase 2
        lock_write(1'b0, 1'b1, 1'b0, e0);
        wait_until(e0 + 49);
        kick_now(k1);
        chk("R8", int'(stage_num), 1, "stage after kick in phase 1");
        expect_ev(0, k1 + 3*FST, "R8");
        wait_until(k1 + 3*FST + 23);
        chk("R8", int'(stage_num), 2, "in phase 2 before kick");
        kick_now(k2);
        chk("R8", int'(stage_num), 1, "stage after kick in phase 2");
        expect_ev(0, k2 + 3*FST, "R8");
        expect_ev(2, k2 + 5*FST, "R8");
        drain();
        clr_flag();

        // R11: kick exactly on each expiry edge; R10: clear on set edge
        kick_now(k1);
        wait_until(k1 + 3*FST - 1);
        kick_now(k2);
        chk("R11", int'(stage_num), 1, "kick on phase-1 expiry stays in phase 1");
        expect_ev(0, k2 + 3*FST, "R11");
        wait_until(k2 + 5*FST - 1);
        kick_now(k1);
        chk("R11", int'(stage_num), 1, "kick on phase-2 expiry restarts phase 1");
        chk("R11", int'(prev_reboot), 0, "no flag when kick wins");
        expect_ev(0, k1 + 3*FST, "R11");
        expect_ev(2, k1 + 5*FST, "R10");
        wait_until(k1 + 5*FST - 1);
        clr_flag();
        chk("R10", int'(prev_reboot), 1, "set wins over clear");
        drain();

        // R9: lock freezes the control write
        lock_write(1'b0, 1'b0, 1'b0, dummy);
        clr_flag();
        lock_write(1'b1, 1'b1, 1'b0, e0);
        expect_ev(0, e0 + 3*FST, "R9");
        expect_ev(2, e0 + 5*FST, "R9");
        repeat (10) @(negedge clk);
        lock_write(1'b0, 1'b0, 1'b0, dummy);
        chk("R9", int'(stage_num), 1, "disable ignored when locked");
        lock_write(1'b0, 1'b1, 1'b1, dummy);
        wait_until(e0 + 5*FST + 2);
        chk("R9", int'(stage_num), 0, "free-run write ignored when locked");
        drain();

        // R1 R3: reset restores defaults; slow scale with preloads of 1
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", int'(prev_reboot), 0, "flag cleared by reset");
        chk("R1", int'(stage_num), 0, "stage after second reset");
        rst_n = 1'b1;
        @(negedge clk);
        pre_write(1, 20'd1);
        pre_write(2, 20'd1);
        lock_write(1'b0, 1'b1, 1'b0, e0);
        chk("R1", int'(stage_num), 1, "lock released by reset");
        expect_ev(0, e0 + 32768, "R3");
        expect_ev(2, e0 + 65536, "R3");
        drain();
        chk("R1", int'(prev_reboot), 1, "default reboot enabled");

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule